// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between an on-chip request bus with a valid/ready handshake and an external asynchronous static RAM that holds 524,288 bytes. It takes one request at a time, either a single-byte read or a single-byte write. It turns each request into a sequence of active-low chip select, active-low output enable and read/write strobes whose durations are counted in clock cycles. Every duration comes from a parameter, worked out as the required nanoseconds divided by the clock period and rounded up. The defaults suit a 100 MHz clock and the fast speed grade: a four-cycle read strobe and a three-cycle write pulse.

The data bus is brought out as three signals: an outgoing byte, a tristate enable and an incoming byte. The pad buffer itself is left to the chip top. A write is controlled by the read/write line. Output enable stays high for the whole write, so the memory never drives the bus. The controller drives the bus only while the read/write line is low. When a write follows a read, idle cycles are inserted so that the memory's output drivers have time to turn off first.

A read samples the memory data on the last cycle of the strobe. The byte is then returned with a one-cycle response pulse. While the controller is idle, the memory is held in standby.

Top module: `xsram_ctl`

## Requirements
- R1: After synchronous reset the strobes are idle: `sram_ce_n`=1, `sram_oe_n`=1, `sram_rw`=1 (1 means read, 0 means write), `sram_dq_oe`=0. `req_ready`=1 and `rsp_valid`=0.
- R2: An accepted read (`req_write`=0) drives `sram_ce_n`=0, `sram_oe_n`=0 and `sram_rw`=1 for exactly RD_CYC cycles. These cycles start in the cycle after acceptance. The strobes then return to idle.
- R3: The byte on `sram_dq_in` during the last read-strobe cycle appears on `rsp_data` in the next cycle, with `rsp_valid`=1 for exactly that one cycle. Data present only earlier in the strobe is not returned.
- R4: An accepted write (`req_write`=1) has three phases, each with `sram_ce_n`=0 and `sram_oe_n`=1 throughout. First come WSET_CYC cycles with `sram_rw`=1. Then come WPUL_CYC cycles with `sram_rw`=0, during which `sram_dq_out` carries the accepted byte. Last come WREC_CYC cycles with `sram_rw`=1.
- R5: `sram_dq_oe` is 1 only in cycles where `sram_rw`=0. It falls in the same cycle that `sram_rw` rises, and the write byte stays stable while it is 1.
- R6: `req_ready` is 1 only while the memory is in standby and no access is in progress. A request offered in the first idle cycle after an access is accepted in that cycle.
- R7: Between the last cycle with `sram_oe_n`=0 and the first cycle with `sram_dq_oe`=1 there are at least TURN_CYC cycles with `sram_ce_n`=1 and `sram_oe_n`=1. No extra cycle is added once that many idle cycles have already passed.
- R8: `sram_addr` carries the address captured at acceptance and stays unchanged for every cycle in which `sram_ce_n`=0, even if `req_addr` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Word address |
| req_wdata | input | DATA_W (8) | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_data | output | DATA_W (8) | Read byte |
| sram_addr | output | ADDR_W (19) | Memory address lines |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_rw | output | 1 | High = read, low = write |
| sram_dq_out | output | DATA_W (8) | Byte driven onto the data bus |
| sram_dq_oe | output | 1 | Tristate enable of the data-bus drivers |
| sram_dq_in | input | DATA_W (8) | Byte received from the data bus |

## Verification
Two functions can fall in the same cycle. In the first idle cycle after a read, the response pulse is presented while a new request is being accepted. The bench provokes this by offering a second read, and separately a write, in exactly that cycle. It then judges that the first read's byte and pulse are correct, and that the new strobe begins one cycle later. When the new request is a write, the bench also checks that the turnaround cycles are inserted and no more. A bench memory model returns valid data only in the final strobe cycle and records any overlap between its output window and the controller's driver enable.

// File: rtl/xsram_pkg.sv
package xsram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_GAP  = 3'd1,
    ST_WSET = 3'd2,
    ST_WPUL = 3'd3,
    ST_WREC = 3'd4,
    ST_READ = 3'd5
  } seq_state_t;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic rw;
    logic dq_oe;
  } strobe_t;

  // Pin levels for each sequencer state.
  function automatic strobe_t strobe_of(seq_state_t s);
    strobe_t r;
    r = '{ce_n: 1'b1, oe_n: 1'b1, rw: 1'b1, dq_oe: 1'b0};
    case (s)
      ST_WSET: r.ce_n = 1'b0;
      ST_WPUL: begin r.ce_n = 1'b0; r.rw = 1'b0; r.dq_oe = 1'b1; end
      ST_WREC: r.ce_n = 1'b0;
      ST_READ: begin r.ce_n = 1'b0; r.oe_n = 1'b0; end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/xsram_timer.sv
module xsram_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/xsram_seq.sv
module xsram_seq
  import xsram_pkg::*;
#(
  parameter int RD_CYC   = 4,
  parameter int WSET_CYC = 1,
  parameter int WPUL_CYC = 3,
  parameter int WREC_CYC = 1,
  parameter int TURN_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic acc_write,
  output logic req_ready,
  output logic sram_ce_n,
  output logic sram_oe_n,
  output logic sram_rw,
  output logic sram_dq_oe,
  output logic capture
);

  localparam int MAX_A = (RD_CYC > WPUL_CYC) ? RD_CYC : WPUL_CYC;
  localparam int MAX_B = (WSET_CYC > WREC_CYC) ? WSET_CYC : WREC_CYC;
  localparam int MAXD  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = (MAXD > 1) ? $clog2(MAXD) : 1;
  localparam int RUN_W = $clog2(MAXD + 2);
  localparam int GAP_W = $clog2(TURN_CYC + 2);

  seq_state_t       state, nxt;
  strobe_t          stb;
  logic             tmr_done, tmr_load, gap_ok;
  logic [CNT_W-1:0] tmr_val;
  logic [GAP_W-1:0] gap_cnt;

  // Idle cycles seen since the last read strobe, counting the current one.
  assign gap_ok = (gap_cnt + GAP_W'(1)) >= GAP_W'(TURN_CYC);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (accept) nxt = acc_write ? (gap_ok ? ST_WSET : ST_GAP) : ST_READ;
      ST_GAP:  if (gap_ok)   nxt = ST_WSET;
      ST_WSET: if (tmr_done) nxt = ST_WPUL;
      ST_WPUL: if (tmr_done) nxt = ST_WREC;
      ST_WREC: if (tmr_done) nxt = ST_IDLE;
      ST_READ: if (tmr_done) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_val = '0;
    case (nxt)
      ST_WSET: tmr_val = CNT_W'(WSET_CYC - 1);
      ST_WPUL: tmr_val = CNT_W'(WPUL_CYC - 1);
      ST_WREC: tmr_val = CNT_W'(WREC_CYC - 1);
      ST_READ: tmr_val = CNT_W'(RD_CYC - 1);
      default: tmr_val = '0;
    endcase
  end

  assign tmr_load = (nxt != state);

  xsram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  assign stb = strobe_of(nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req_ready  <= 1'b1;
      sram_ce_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_rw    <= 1'b1;
      sram_dq_oe <= 1'b0;
      gap_cnt    <= GAP_W'(TURN_CYC);
    end else begin
      state      <= nxt;
      req_ready  <= (nxt == ST_IDLE);
      sram_ce_n  <= stb.ce_n;
      sram_oe_n  <= stb.oe_n;
      sram_rw    <= stb.rw;
      sram_dq_oe <= stb.dq_oe;
      if (state == ST_READ)
        gap_cnt <= '0;
      else if ((state == ST_IDLE || state == ST_GAP) && gap_cnt < GAP_W'(TURN_CYC))
        gap_cnt <= gap_cnt + GAP_W'(1);
    end
  end

  assign capture = (state == ST_READ) && tmr_done;

  // ---------------- checks on the strobe pins ----------------
  logic [RUN_W-1:0] rd_run, wr_run;
  logic [GAP_W-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_run <= '0;
      wr_run <= '0;
      hi_run <= GAP_W'(TURN_CYC);
    end else begin
      rd_run <= sram_oe_n ? '0 : rd_run + RUN_W'(1);
      wr_run <= sram_rw   ? '0 : wr_run + RUN_W'(1);
      if (!sram_oe_n)
        hi_run <= '0;
      else if (sram_ce_n && hi_run < GAP_W'(TURN_CYC))
        hi_run <= hi_run + GAP_W'(1);
    end
  end

  // R2: the read strobe lasts exactly RD_CYC cycles
  assert_read_len_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_oe_n) |-> rd_run == RUN_W'(RD_CYC));

  // R4: the write pulse lasts exactly WPUL_CYC cycles
  assert_wpulse_len_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_rw) |-> wr_run == RUN_W'(WPUL_CYC));

  // R5: during a write pulse the memory outputs stay disabled and selected
  assert_write_oe_high_R5: assert property (@(posedge clk) disable iff (rst)
    !sram_rw |-> (sram_oe_n && !sram_ce_n));

  // R7: enough released cycles before the data drivers turn on
  assert_turnaround_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_dq_oe) |-> hi_run >= GAP_W'(TURN_CYC));

  // R6: ready only while in standby
  assert_ready_idle_R6: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> sram_ce_n);

endmodule

// File: rtl/xsram_dpath.sv
module xsram_dpath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr   <= '0;
      sram_dq_out <= '0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
    end else begin
      if (accept) begin
        sram_addr   <= req_addr;
        sram_dq_out <= req_wdata;
      end
      rsp_valid <= capture;
      if (capture) rsp_data <= sram_dq_in;
    end
  end

endmodule

// File: rtl/xsram_ctl.sv
module xsram_ctl #(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int RD_CYC   = 4,
  parameter int WSET_CYC = 1,
  parameter int WPUL_CYC = 3,
  parameter int WREC_CYC = 1,
  parameter int TURN_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_rw,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  logic accept, capture;

  assign accept = req_valid && req_ready;

  xsram_seq #(
    .RD_CYC   (RD_CYC),
    .WSET_CYC (WSET_CYC),
    .WPUL_CYC (WPUL_CYC),
    .WREC_CYC (WREC_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .acc_write  (req_write),
    .req_ready  (req_ready),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n),
    .sram_rw    (sram_rw),
    .sram_dq_oe (sram_dq_oe),
    .capture    (capture)
  );

  xsram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .capture     (capture),
    .sram_dq_in  (sram_dq_in),
    .sram_addr   (sram_addr),
    .sram_dq_out (sram_dq_out),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data)
  );

  // R3: a response follows the final read-strobe cycle and lasts one cycle
  assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(!sram_oe_n) && sram_oe_n));

  // R8: address frozen while the memory is selected
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

  // R5: write byte frozen while the drivers are on
  assert_wdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));

endmodule

// File: tb/tb_xsram_ctl.sv
module tb_xsram_ctl;

  localparam int AW = 19, DW = 8;
  localparam int RD = 4, WS = 1, WP = 3, WR = 1, TC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, sram_ce_n, sram_oe_n, sram_rw, sram_dq_oe;
  logic [DW-1:0] rsp_data, sram_dq_out, sram_dq_in;
  logic [AW-1:0] sram_addr;

  xsram_ctl #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD), .WSET_CYC(WS),
              .WPUL_CYC(WP), .WREC_CYC(WR), .TURN_CYC(TC)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_rw(sram_rw),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // ---------------- memory model (256 bytes, low address bits) ----------------
  logic [DW-1:0] mem [256];
  int            rd_age;
  logic          rd_mode, out_hold, wpend;
  logic [7:0]    w_idx;
  logic [DW-1:0] w_byte;
  int            clash;

  assign rd_mode = !sram_ce_n && !sram_oe_n && sram_rw;
  // data valid only once the strobe has lasted the full access window
  assign sram_dq_in = (rd_mode && rd_age >= RD - 1) ? mem[sram_addr[7:0]] : 8'hEE;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  end

  always @(posedge clk) begin
    if (rst) begin
      rd_age <= 0; out_hold <= 1'b0; wpend <= 1'b0; clash <= 0;
    end else begin
      rd_age   <= rd_mode ? rd_age + 1 : 0;
      out_hold <= rd_mode;
      if (sram_dq_oe && (rd_mode || out_hold)) clash <= clash + 1;
      if (!sram_ce_n && !sram_rw && sram_dq_oe) begin
        wpend <= 1'b1; w_idx <= sram_addr[7:0]; w_byte <= sram_dq_out;
      end else if (wpend && sram_rw) begin
        wpend <= 1'b0; mem[w_idx] <= w_byte;
      end
    end
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pins();
    return {sram_ce_n, sram_oe_n, sram_rw, sram_dq_oe};
  endfunction

  // Called at a negedge in an idle cycle; ends at the negedge of the response cycle.
  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    chk(req_ready == 1'b1, "R6 ready before read", req_ready, 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a;
    for (int i = 0; i < RD; i++) begin
      chk(pins() == 4'b0010, "R2 read strobe", pins(), 4'b0010);
      chk(sram_addr == a, "R8 read address", sram_addr, a);
      chk(!req_ready && !rsp_valid, "R6 busy during read", {req_ready, rsp_valid}, 0);
      @(negedge clk);
    end
    chk(rsp_valid && rsp_data == exp, "R3 read data", {rsp_valid, rsp_data}, {1'b1, exp});
    chk(pins() == 4'b1110, "R2 strobe released", pins(), 4'b1110);
    chk(req_ready == 1'b1, "R6 ready after read", req_ready, 1);
  endtask

  // Called at a negedge in an idle cycle; ends at the negedge of the first idle cycle.
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int gap);
    chk(req_ready == 1'b1, "R6 ready before write", req_ready, 1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
    for (int i = 0; i < gap; i++) begin
      chk(pins() == 4'b1110, "R7 turnaround idle", pins(), 4'b1110);
      @(negedge clk);
    end
    for (int i = 0; i < WS; i++) begin
      chk(pins() == 4'b0110, "R4 write setup", pins(), 4'b0110);
      chk(sram_addr == a, "R8 write address", sram_addr, a);
      @(negedge clk);
    end
    for (int i = 0; i < WP; i++) begin
      chk(pins() == 4'b0101, "R5 write pulse strobes", pins(), 4'b0101);
      chk(sram_dq_out == d, "R4 write byte", sram_dq_out, d);
      chk(sram_addr == a, "R8 write address", sram_addr, a);
      @(negedge clk);
    end
    for (int i = 0; i < WR; i++) begin
      chk(pins() == 4'b0110, "R5 driver off at rw rise", pins(), 4'b0110);
      @(negedge clk);
    end
    chk(pins() == 4'b1110 && req_ready, "R6 idle after write", {pins(), req_ready}, 5'b11101);
  endtask

  task automatic t_reset();
    chk(pins() == 4'b1110, "R1 reset strobes", pins(), 4'b1110);
    chk(req_ready && !rsp_valid, "R1 reset handshake", {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic t_write_read();
    do_write(19'h7FF12, 8'hA1, 0);
    do_read(19'h7FF12, 8'hA1);
    @(negedge clk);
    chk(!rsp_valid, "R3 single-cycle pulse", rsp_valid, 0);
  endtask

  task automatic t_back_to_back_reads();
    do_write(19'h00034, 8'h5C, 0);
    do_write(19'h40056, 8'h3E, 0);       // write right after write: no gap
    do_read(19'h00034, 8'h5C);
    do_read(19'h40056, 8'h3E);           // accepted in the response cycle
    @(negedge clk);
    chk(!rsp_valid, "R3 pulse ends", rsp_valid, 0);
  endtask

  task automatic t_turnaround();
    do_read(19'h00034, 8'h5C);
    do_write(19'h12378, 8'hC7, TC - 1);  // accepted in the response cycle
    do_read(19'h12378, 8'hC7);
    @(negedge clk);
    do_write(19'h7FF12, 8'h69, (TC > 2) ? TC - 2 : 0); // one idle cycle already passed
    do_read(19'h7FF12, 8'h69);
    @(negedge clk);
    chk(clash == 0, "R7 no bus overlap", clash, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_back_to_back_reads();
    t_turnaround();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule